// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block sequences analog-to-digital conversions over a small, contiguous range of input channels. Software programs a control word that holds a mode, a first and a last channel, a routing choice for the end-of-conversion event, and a start/busy bit. While a sequence runs, the block sends a one-cycle start pulse and a channel number to an external converter. It then waits for the converter's done pulse before it moves to the next channel.

There are three modes. Single mode converts one channel and stops. Multi mode converts each channel in the range once, in ascending order, and stops. Scan mode repeats the range until software stops it. A falling edge on an external trigger pin can also start a sequence, but only in single and scan modes. Each completed sequence, or each completed pass in scan mode, produces one end-of-conversion event. That event goes either to a held interrupt level or to a one-cycle DMA request.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0, and `irq`, `dma_req` and `conv_start` are 0.
- R2: The control word has these fields: mode in bits [1:0] (0 = single, 1 = multi, 2 or 3 = scan), first channel in bits [5:4], last channel in bits [9:8], routing in bit 12 and start/busy in bit 13. Every field written while idle reads back unchanged. Bit 13 reads 1 for as long as a sequence is active.
- R3: In single mode, writing bit 13 = 1 converts the first channel exactly once, after which bit 13 returns to 0 by itself. While that conversion is in progress, a write with bit 13 = 0 is ignored.
- R4: In multi mode, the block converts each channel from first to last once, in ascending order. It then clears bit 13 by itself and raises one end-of-conversion event.
- R5: In multi mode, a write with bit 13 = 0 lets the channel in progress finish. No further channel is started, bit 13 clears when that channel's done pulse arrives, and no end-of-conversion event is raised.
- R6: In scan mode, the block cycles through first to last repeatedly and raises one end-of-conversion event after each completed pass. A write with bit 13 = 0 stops the sequence after the current channel, with no event.
- R7: `conv_start` is a one-cycle pulse. `conv_chan` holds steady until `conv_done` arrives, and no new start is issued before that done pulse.
- R8: When idle in single or scan mode, a falling edge on `ext_trig_n`, seen through a two-stage synchroniser, starts a sequence. Holding the pin low produces only one start.
- R9: In multi mode, falling edges on `ext_trig_n` start nothing.
- R10: With routing bit 12 = 0, an end-of-conversion event sets `irq`, which stays high until `irq_ack` is pulsed.
- R11: With routing bit 12 = 1, each end-of-conversion event produces a one-cycle `dma_req`, and `irq` stays 0.
- R12: While bit 13 reads 1, writes to the mode, channel and routing fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write value |
| ctrl_rdata | output | 16 | Control word readback |
| ext_trig_n | input | 1 | Asynchronous external trigger, falling-edge active |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_chan | output | 2 | Channel being converted |
| conv_done | input | 1 | One-cycle done pulse from the converter |
| irq | output | 1 | End-of-conversion interrupt level |
| irq_ack | input | 1 | Clears `irq` |
| dma_req | output | 1 | End-of-conversion DMA request pulse |

## Verification
If the sequencing state is wrong, a wrong channel number or an extra or missing start pulse appears at the converter handshake on the very next launch, one cycle after a done pulse is accepted. If the stop or completion logic is wrong, bit 13 of the readback stays high or drops too early, and this shows within one cycle of the final done pulse. A misrouted or duplicated end-of-conversion event shows on `irq` or `dma_req` in that same cycle. A fault in the trigger path shows as a missing or repeated start about three cycles after the pin falls.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic [1:0] {
      MODE_SINGLE = 2'd0,
      MODE_MULTI  = 2'd1,
      MODE_SCAN   = 2'd2,
      MODE_SCAN2  = 2'd3
   } adc_mode_t;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_LAUNCH = 2'd1,
      PH_WAIT   = 2'd2
   } adc_phase_t;
endpackage

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_n_async,
   output logic trig_fall
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("adc_trig_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[0] <= 1'b1;
               else        chain_q[0] <= trig_n_async;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[i] <= 1'b1;
               else        chain_q[i] <= chain_q[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];

   assign trig_fall = prev_q & ~chain_q[STAGES-1];

   a_r8_one_start_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
      trig_fall |=> !trig_fall);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_cmd,
   input  logic [CH_W-1:0] start_first,
   input  logic            stop_cmd,
   input  adc_mode_t       mode,
   input  logic [CH_W-1:0] first_ch,
   input  logic [CH_W-1:0] last_ch,
   input  logic            conv_done,
   output logic            busy,
   output logic            conv_start,
   output logic [CH_W-1:0] conv_chan,
   output logic            eoc
);
   adc_phase_t      phase_q, phase_d;
   logic [CH_W-1:0] cur_q, cur_d;
   logic            stop_q;
   logic            is_scan;

   assign is_scan = mode[1];

   always_comb begin
      phase_d = phase_q;
      cur_d   = cur_q;
      eoc     = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (start_cmd) begin
               phase_d = PH_LAUNCH;
               cur_d   = start_first;
            end
         end
         PH_LAUNCH: phase_d = PH_WAIT;
         PH_WAIT: begin
            if (conv_done) begin
               if (stop_q) begin
                  phase_d = PH_IDLE;
               end else if (mode == MODE_SINGLE) begin
                  phase_d = PH_IDLE;
                  eoc     = 1'b1;
               end else if (cur_q == last_ch) begin
                  eoc = 1'b1;
                  if (is_scan) begin
                     phase_d = PH_LAUNCH;
                     cur_d   = first_ch;
                  end else begin
                     phase_d = PH_IDLE;
                  end
               end else begin
                  phase_d = PH_LAUNCH;
                  cur_d   = cur_q + 1'b1;
               end
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cur_q   <= '0;
         stop_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         cur_q   <= cur_d;
         if (phase_d == PH_IDLE)        stop_q <= 1'b0;
         else if (stop_cmd && busy)     stop_q <= 1'b1;
      end
   end

   assign busy       = (phase_q != PH_IDLE);
   assign conv_start = (phase_q == PH_LAUNCH);
   assign conv_chan  = cur_q;

   a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   a_r7_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_WAIT && !conv_done) |=> ($stable(conv_chan) && !conv_start));
   a_r5_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(phase_q == PH_WAIT && conv_done)) |=> busy);
   a_r5_no_eoc_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      stop_q |-> !eoc);
endmodule

// File: rtl/adc_eoc_route.sv
module adc_eoc_route (
   input  logic clk,
   input  logic rst_n,
   input  logic eoc,
   input  logic to_dma,
   input  logic irq_ack,
   output logic irq,
   output logic dma_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq     <= 1'b0;
         dma_req <= 1'b0;
      end else begin
         dma_req <= eoc & to_dma;
         if (eoc && !to_dma) irq <= 1'b1;
         else if (irq_ack)   irq <= 1'b0;
      end
   end

   a_r10_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);
   a_r11_dma_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |=> !dma_req);
   a_r11_no_irq_on_dma: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !(eoc && !to_dma)) |=> !irq);
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int DATA_W      = 16,
   parameter int START_BIT   = 13,
   parameter int ROUTE_BIT   = 12,
   parameter int FIRST_LSB   = 4,
   parameter int LAST_LSB    = 8,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ctrl_rdata,
   input  logic              ext_trig_n,
   output logic              conv_start,
   output logic [CH_W-1:0]   conv_chan,
   input  logic              conv_done,
   output logic              irq,
   input  logic              irq_ack,
   output logic              dma_req
);
   generate
      if (NUM_CH < 2 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
         $error("NUM_CH must be a power of two of at least 2");
      end
      if (START_BIT >= DATA_W || ROUTE_BIT >= DATA_W || START_BIT == ROUTE_BIT) begin : g_bad_bits
         $error("start and routing bits must be distinct and inside the word");
      end
      if (FIRST_LSB < 2 || FIRST_LSB + CH_W > LAST_LSB || LAST_LSB + CH_W > ROUTE_BIT
          || LAST_LSB + CH_W > START_BIT) begin : g_bad_fields
         $error("channel fields overlap other fields");
      end
   endgenerate

   adc_mode_t       mode_q;
   logic [CH_W-1:0] first_q, last_q;
   logic            route_q;
   logic            busy, trig_fall, eoc;
   logic            cfg_we, start_cmd, stop_cmd;
   logic [CH_W-1:0] start_first;

   assign cfg_we = wr_en & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q  <= MODE_SINGLE;
         first_q <= '0;
         last_q  <= '0;
         route_q <= 1'b0;
      end else if (cfg_we) begin
         mode_q  <= adc_mode_t'(wr_data[1:0]);
         first_q <= wr_data[FIRST_LSB +: CH_W];
         last_q  <= wr_data[LAST_LSB +: CH_W];
         route_q <= wr_data[ROUTE_BIT];
      end
   end

   assign start_cmd   = (cfg_we & wr_data[START_BIT])
                      | (trig_fall & ~busy & ~wr_en & (mode_q != MODE_MULTI));
   assign start_first = cfg_we ? wr_data[FIRST_LSB +: CH_W] : first_q;
   assign stop_cmd    = wr_en & busy & ~wr_data[START_BIT] & (mode_q != MODE_SINGLE);

   always_comb begin
      ctrl_rdata                      = '0;
      ctrl_rdata[1:0]                 = mode_q;
      ctrl_rdata[FIRST_LSB +: CH_W]   = first_q;
      ctrl_rdata[LAST_LSB +: CH_W]    = last_q;
      ctrl_rdata[ROUTE_BIT]           = route_q;
      ctrl_rdata[START_BIT]           = busy;
   end

   adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .trig_n_async(ext_trig_n), .trig_fall(trig_fall));

   adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .start_first(start_first),
      .stop_cmd(stop_cmd), .mode(mode_q), .first_ch(first_q), .last_ch(last_q),
      .conv_done(conv_done), .busy(busy), .conv_start(conv_start),
      .conv_chan(conv_chan), .eoc(eoc));

   adc_eoc_route u_route (
      .clk(clk), .rst_n(rst_n), .eoc(eoc), .to_dma(route_q), .irq_ack(irq_ack),
      .irq(irq), .dma_req(dma_req));

   a_r12_route_locked: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(route_q));
   a_r12_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(mode_q) && $stable(first_q) && $stable(last_q)));
   a_r9_no_trig_multi: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wr_en && mode_q == MODE_MULTI) |=> !busy);
endmodule

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int LAT        = 3;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        wr_en = 1'b0, ext_trig_n = 1'b1, conv_done = 1'b0, irq_ack = 1'b0;
   logic [15:0] wr_data = '0, ctrl_rdata;
   logic        conv_start, irq, dma_req;
   logic [1:0]  conv_chan;

   int checks = 0, failures = 0;
   int num_starts = 0, dma_cnt = 0, r7_viol = 0, cnt = 0;
   int chan_log [0:63];

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_seq_ctrl i_adc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .ctrl_rdata(ctrl_rdata), .ext_trig_n(ext_trig_n), .conv_start(conv_start),
      .conv_chan(conv_chan), .conv_done(conv_done), .irq(irq), .irq_ack(irq_ack),
      .dma_req(dma_req));

   // fixed-latency converter model and event counters
   logic prev_start = 1'b0;
   always @(negedge clk) begin
      conv_done = 1'b0;
      if (cnt > 0) begin
         cnt = cnt - 1;
         if (cnt == 0) conv_done = 1'b1;
      end
      if (conv_start) begin
         if (prev_start || cnt > 0 || conv_done) r7_viol = r7_viol + 1;
         if (num_starts < 64) chan_log[num_starts] = int'(conv_chan);
         num_starts = num_starts + 1;
         cnt = LAT;
      end
      prev_start = conv_start;
      if (dma_req) dma_cnt = dma_cnt + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic write_reg(input logic [15:0] v);
      wr_en = 1'b1; wr_data = v;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 500 && ctrl_rdata[13]; i++) tick();
   endtask

   task automatic wait_starts(input int n);
      for (int i = 0; i < 500 && num_starts < n; i++) tick();
   endtask

   task automatic clear_log();
      num_starts = 0; dma_cnt = 0;
   endtask

   task automatic ack_irq();
      irq_ack = 1'b1; tick(); irq_ack = 1'b0;
   endtask

   function automatic logic [15:0] cw(input int mode, input int f, input int l,
                                      input bit route, input bit start);
      logic [15:0] v = '0;
      v[1:0] = mode[1:0]; v[5:4] = f[1:0]; v[9:8] = l[1:0];
      v[12] = route; v[13] = start;
      return v;
   endfunction

   task automatic t_reset();
      check(ctrl_rdata == 16'h0, "R1 rdata", int'(ctrl_rdata), 0);
      check(!irq && !dma_req && !conv_start, "R1 outputs", int'({irq, dma_req, conv_start}), 0);
   endtask

   task automatic t_register();
      write_reg(cw(1, 1, 3, 1'b1, 1'b0));
      check(ctrl_rdata == 16'h1311, "R2 readback", int'(ctrl_rdata), 'h1311);
      write_reg(cw(2, 0, 2, 1'b0, 1'b0));
      check(ctrl_rdata == 16'h0202, "R2 readback2", int'(ctrl_rdata), 'h0202);
   endtask

   task automatic t_single();
      clear_log();
      write_reg(cw(0, 2, 2, 1'b0, 1'b1));
      check(ctrl_rdata[13] == 1'b1, "R2 busy reads 1", int'(ctrl_rdata[13]), 1);
      write_reg(cw(0, 2, 2, 1'b0, 1'b0));
      check(ctrl_rdata[13] == 1'b1, "R3 clear ignored", int'(ctrl_rdata[13]), 1);
      wait_idle();
      check(num_starts == 1, "R3 one start", num_starts, 1);
      check(chan_log[0] == 2, "R3 channel", chan_log[0], 2);
      tick(4);
      check(irq == 1'b1, "R10 irq held", int'(irq), 1);
      ack_irq();
      check(irq == 1'b0, "R10 irq acked", int'(irq), 0);
   endtask

   task automatic t_multi();
      clear_log();
      write_reg(cw(1, 0, 3, 1'b1, 1'b1));
      wait_idle();
      tick(2);
      check(num_starts == 4, "R4 start count", num_starts, 4);
      for (int i = 0; i < 4; i++)
         check(chan_log[i] == i, "R4 channel order", chan_log[i], i);
      check(dma_cnt == 1, "R11 one dma pulse", dma_cnt, 1);
      check(irq == 1'b0, "R11 no irq", int'(irq), 0);
      check(r7_viol == 0, "R7 handshake", r7_viol, 0);
   endtask

   task automatic t_multi_stop();
      clear_log();
      write_reg(cw(1, 0, 3, 1'b0, 1'b1));
      wait_starts(2);
      write_reg(cw(1, 0, 3, 1'b0, 1'b0));
      check(ctrl_rdata[13] == 1'b1, "R5 finishes current", int'(ctrl_rdata[13]), 1);
      wait_idle();
      tick(8);
      check(num_starts == 2, "R5 no next channel", num_starts, 2);
      check(irq == 1'b0, "R5 no event", int'(irq), 0);
   endtask

   task automatic t_scan();
      clear_log();
      write_reg(cw(2, 1, 2, 1'b1, 1'b1));
      wait_starts(6);
      for (int i = 0; i < 6; i++)
         check(chan_log[i] == 1 + (i % 2), "R6 scan order", chan_log[i], 1 + (i % 2));
      check(dma_cnt == 2, "R6 event per pass", dma_cnt, 2);
      write_reg(cw(2, 1, 2, 1'b1, 1'b0));
      wait_idle();
      tick(8);
      check(num_starts == 6, "R6 stop after current", num_starts, 6);
      check(dma_cnt == 2, "R6 no event on stop", dma_cnt, 2);
      check(r7_viol == 0, "R7 handshake scan", r7_viol, 0);
   endtask

   task automatic t_trig_single();
      write_reg(cw(0, 3, 3, 1'b0, 1'b0));
      clear_log();
      ext_trig_n = 1'b0;
      tick(30);
      check(num_starts == 1, "R8 one start per edge", num_starts, 1);
      check(chan_log[0] == 3, "R8 channel", chan_log[0], 3);
      check(irq == 1'b1, "R8 event", int'(irq), 1);
      ext_trig_n = 1'b1;
      tick(4);
      ack_irq();
   endtask

   task automatic t_trig_multi();
      write_reg(cw(1, 0, 1, 1'b0, 1'b0));
      clear_log();
      ext_trig_n = 1'b0; tick(6); ext_trig_n = 1'b1; tick(10);
      check(num_starts == 0, "R9 trigger ignored", num_starts, 0);
      check(ctrl_rdata[13] == 1'b0, "R9 stays idle", int'(ctrl_rdata[13]), 0);
   endtask

   task automatic t_lock();
      clear_log();
      write_reg(cw(0, 0, 0, 1'b0, 1'b1));
      write_reg(cw(1, 3, 3, 1'b1, 1'b1));
      check(ctrl_rdata == 16'h2000, "R12 fields locked", int'(ctrl_rdata), 'h2000);
      wait_idle();
      tick(2);
      check(irq == 1'b1 && dma_cnt == 0, "R12 routing kept", int'(irq), 1);
      ack_irq();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_register();
      t_single();
      t_multi();
      t_multi_stop();
      t_scan();
      t_trig_single();
      t_trig_multi();
      t_lock();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule